// File: doc/BRIEF.md
# Controller Command Responder with Seconds Clock

This block sits behind a byte link that carries host packets to a system controller. Each packet arrives as a framed byte stream. The first byte is a packet type, the second a command code, and any further bytes are parameters. The block decodes controller-command packets and writes a reply packet onto an outgoing byte stream, one byte per cycle. The reply carries its total length on a side output for as long as it is being sent. The block handles only the command set listed below. Traffic for the attached peripheral bus, and any memory or two-wire-bus service, belongs to other logic, apart from the error replies this block sends for the two-wire-bus commands.

The block keeps a 32-bit seconds count that advances on an external one-second tick enable. Software can read the count and load it. The count holds seconds since the start of 1904. A command switches periodic polling on or off. While polling is on, the block sends a short poll reply at a fixed cycle interval. At 50 MHz the default interval gives 50 polls per second. The power-down and system-reset commands are acknowledged first. A one-cycle request pulse follows on a dedicated output.

Top module: `cmd_responder`

## Requirements
- R1: A packet is the run of accepted bytes from a byte flagged `in_first` up to and including one flagged `in_last` (both flags may mark the same byte). Bytes presented while no packet is open are ignored. Only packets of two or more bytes whose type byte is 0x01 (controller command) are answered. Other types (0x00 peripheral bus, 0x02 error, 0x03 timer, 0x04 power) produce no reply.
- R2: Commands 0x01, 0x09, 0x0A, 0x11, 0x13, 0x14, 0x19 and 0x21, and command 0x22 carrying exactly two parameter bytes, are each answered with the three bytes 0x01, 0x00, command.
- R3: Command 0x03 is answered with seven bytes: 0x01, 0x00, 0x03, then the seconds count as it stands in the cycle the packet is decoded, most significant byte first.
- R4: Command 0x09 with at least four parameter bytes loads the seconds count from the first four, most significant first. A load in the same cycle as a tick wins over the tick. With fewer parameters it is acknowledged and the count is left unchanged.
- R5: The seconds count increments by one at every clock edge where `sec_tick` is high.
- R6: Command 0x25, and command 0x22 with other than exactly two parameter bytes, are answered with the four bytes 0x02, `ERR_CODE`, 0x01, command.
- R7: A controller command with any other code produces no reply and changes no state.
- R8: Command 0x01 enables polling if its first parameter is present and nonzero, and disables it otherwise. Enabling from off, or disabling, clears the interval counter and any pending poll. Repeating the current setting has no effect. While polling is on, a poll becomes pending every `POLL_PERIOD` cycles. A pending poll is sent as the two bytes 0x00, 0x40 once the output is free, unless a command reply is loaded in that same cycle.
- R9: A reply's first byte appears two cycles after the cycle that presents the packet's end byte. One byte follows per cycle. `out_first` marks the first byte and `out_last` the last. `out_len` holds the reply length throughout and reads 0 when idle. A new reply may start in the cycle after the previous one's last byte.
- R10: A packet that completes while a reply is still being sent, other than on its last byte, is discarded whole. It gets no reply and has no effect.
- R11: `shutdown_req` (after a 0x0A reply) or `reset_req` (after a 0x11 reply) is high for exactly the one cycle that follows the reply's last byte.
- R12: After reset the outputs are idle, both request pulses are low, the seconds count is 0 and polling is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming byte present |
| in_first | input | 1 | Byte opens a packet |
| in_last | input | 1 | Byte closes a packet |
| in_data | input | 8 | Incoming byte |
| sec_tick | input | 1 | One-second tick enable |
| out_valid | output | 1 | Reply byte present |
| out_first | output | 1 | First byte of a reply |
| out_last | output | 1 | Last byte of a reply |
| out_data | output | 8 | Reply byte |
| out_len | output | 3 | Length of the reply in progress, 0 when idle |
| shutdown_req | output | 1 | One-cycle power-down request |
| reset_req | output | 1 | One-cycle system-reset request |

## Verification
Each command code is sent in isolation with spaced packets. This separates the acknowledge, error, time and silent responses, and for 0x22 and 0x09 it separates the parameter counts that choose between them. Back-to-back packets check that a packet finishing during a reply is dropped, including a time load whose effect must not appear. Ticks are held high across a time load to show that the load takes priority. Command traffic is also sent while polling runs, so poll and command replies collide and the command reply must go first with the poll deferred. Unframed bytes, single-byte packets and non-command types check that nothing is emitted.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int BYTE_W    = 8;
  localparam int SEC_W     = 32;
  localparam int REPLY_MAX = 7;
  localparam int LEN_W     = $clog2(REPLY_MAX + 1);
  localparam int PKT_KEEP  = 6;
  localparam int CNT_W     = 4;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_SHUTDOWN = 2'd1,
    ACT_RESET    = 2'd2
  } act_e;

  localparam logic [7:0] TYPE_PERIPH = 8'h00;
  localparam logic [7:0] TYPE_CTRL   = 8'h01;
  localparam logic [7:0] TYPE_ERR    = 8'h02;
  localparam logic [7:0] POLL_TAG    = 8'h40;

  localparam logic [7:0] OP_AUTOPOLL  = 8'h01;
  localparam logic [7:0] OP_TIME_RD   = 8'h03;
  localparam logic [7:0] OP_TIME_WR   = 8'h09;
  localparam logic [7:0] OP_POWER_OFF = 8'h0A;
  localparam logic [7:0] OP_SYS_RESET = 8'h11;
  localparam logic [7:0] OP_NOP_SRV   = 8'h13;
  localparam logic [7:0] OP_NOP_RATE  = 8'h14;
  localparam logic [7:0] OP_NOP_LIST  = 8'h19;
  localparam logic [7:0] OP_NOP_PWR   = 8'h21;
  localparam logic [7:0] OP_WIRE_RW   = 8'h22;
  localparam logic [7:0] OP_WIRE_CMB  = 8'h25;
endpackage

// File: rtl/cpr_pkt_collect.sv
module cpr_pkt_collect #(
  parameter int KEEP  = 6,
  parameter int CNT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_first,
  input  logic                      in_last,
  input  logic [7:0]                in_data,
  output logic                      pkt_done,
  output logic [KEEP-1:0][7:0]      pkt_bytes,
  output logic [CNT_W-1:0]          pkt_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                 open_q, open_d;
  logic                 done_q, done_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [KEEP-1:0][7:0] buf_q, buf_d;

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    buf_d  = buf_q;
    done_d = 1'b0;
    if (in_valid) begin
      if (in_first) begin
        open_d   = 1'b1;
        cnt_d    = CNT_W'(1);
        buf_d[0] = in_data;
      end else if (open_q) begin
        for (int i = 0; i < KEEP; i++) begin
          if (cnt_q == CNT_W'(i)) buf_d[i] = in_data;
        end
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      if (in_last && (in_first || open_q)) begin
        done_d = 1'b1;
        open_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      buf_q  <= '0;
    end else begin
      open_q <= open_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      buf_q  <= buf_d;
    end
  end

  assign pkt_done  = done_q;
  assign pkt_bytes = buf_q;
  assign pkt_cnt   = cnt_q;
endmodule

// File: rtl/cpr_seconds.sv
module cpr_seconds #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] secs
);
  logic [W-1:0] secs_q, secs_d;

  always_comb begin
    secs_d = secs_q;
    if (load)      secs_d = load_val;
    else if (tick) secs_d = secs_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) secs_q <= '0;
    else        secs_q <= secs_d;
  end

  assign secs = secs_q;
endmodule

// File: rtl/cpr_poll_gen.sv
module cpr_poll_gen #(
  parameter int PERIOD = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_en,
  input  logic serve,
  output logic pend
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          en_q, en_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = en_q && (cnt_q == LAST);

  always_comb begin
    en_d   = en_q;
    cnt_d  = cnt_q;
    pend_d = (pend_q && !serve) || wrap;
    if (en_q) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    if (cfg_we && (cfg_en != en_q)) begin
      en_d   = cfg_en;
      cnt_d  = '0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/cpr_reply_tx.sv
module cpr_reply_tx
  import cpr_pkg::*;
#(
  parameter int MAXB = 7,
  parameter int LW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [MAXB-1:0][7:0] load_bytes,
  input  logic [LW-1:0]        load_len,
  input  act_e                 load_act,
  output logic                 free,
  output logic                 out_valid,
  output logic                 out_first,
  output logic                 out_last,
  output logic [7:0]           out_data,
  output logic [LW-1:0]        out_len,
  output logic                 shut_pulse,
  output logic                 rst_pulse
);
  logic [MAXB-1:0][7:0] buf_q, buf_d;
  logic [LW-1:0]        len_q, len_d;
  logic [LW-1:0]        idx_q, idx_d;
  logic                 busy_q, busy_d;
  act_e                 act_q, act_d;
  logic                 shut_q, shut_d;
  logic                 rstp_q, rstp_d;
  logic                 last_now;

  assign last_now = busy_q && (idx_q == len_q - 1'b1);
  assign free     = !busy_q || last_now;

  always_comb begin
    buf_d  = buf_q;
    len_d  = len_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    act_d  = act_q;
    shut_d = last_now && (act_q == ACT_SHUTDOWN);
    rstp_d = last_now && (act_q == ACT_RESET);
    if (busy_q) begin
      if (last_now) busy_d = 1'b0;
      else          idx_d  = idx_q + 1'b1;
    end
    if (load && free) begin
      buf_d  = load_bytes;
      len_d  = load_len;
      idx_d  = '0;
      busy_d = (load_len != '0);
      act_d  = load_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      act_q  <= ACT_NONE;
      shut_q <= 1'b0;
      rstp_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      len_q  <= len_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
      act_q  <= act_d;
      shut_q <= shut_d;
      rstp_q <= rstp_d;
    end
  end

  assign out_valid  = busy_q;
  assign out_first  = busy_q && (idx_q == '0);
  assign out_last   = last_now;
  assign out_data   = buf_q[idx_q];
  assign out_len    = busy_q ? len_q : '0;
  assign shut_pulse = shut_q;
  assign rst_pulse  = rstp_q;
endmodule

// File: rtl/cmd_responder.sv
module cmd_responder
  import cpr_pkg::*;
#(
  parameter int         POLL_PERIOD = 1_000_000,
  parameter logic [7:0] ERR_CODE    = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_first,
  input  logic       in_last,
  input  logic [7:0] in_data,
  input  logic       sec_tick,
  output logic       out_valid,
  output logic       out_first,
  output logic       out_last,
  output logic [7:0] out_data,
  output logic [2:0] out_len,
  output logic       shutdown_req,
  output logic       reset_req
);
  logic                      pkt_done;
  logic [PKT_KEEP-1:0][7:0]  pkt_b;
  logic [CNT_W-1:0]          pkt_n;
  logic [SEC_W-1:0]          secs;
  logic                      poll_pend;
  logic                      tx_free;

  logic [7:0]                typ, op;
  logic                      is_cmd, accept;
  logic [REPLY_MAX-1:0][7:0] rep_b, ld_b;
  logic [LEN_W-1:0]          rep_len, ld_len;
  act_e                      rep_act, ld_act;
  logic                      time_ld, ap_we, ap_en;
  logic                      cmd_load, poll_serve;

  cpr_pkt_collect #(.KEEP(PKT_KEEP), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .pkt_done(pkt_done),
    .pkt_bytes(pkt_b), .pkt_cnt(pkt_n)
  );

  assign typ    = pkt_b[0];
  assign op     = pkt_b[1];
  assign is_cmd = pkt_done && (pkt_n >= CNT_W'(2)) && (typ == TYPE_CTRL);
  assign accept = is_cmd && tx_free;

  always_comb begin
    rep_b   = '0;
    rep_b[0] = TYPE_CTRL;
    rep_b[1] = 8'h00;
    rep_b[2] = op;
    rep_len = '0;
    rep_act = ACT_NONE;
    time_ld = 1'b0;
    ap_we   = 1'b0;
    ap_en   = 1'b0;
    unique case (op)
      OP_AUTOPOLL: begin
        rep_len = LEN_W'(3);
        ap_we   = 1'b1;
        ap_en   = (pkt_n >= CNT_W'(3)) && (pkt_b[2] != 8'h00);
      end
      OP_TIME_RD: begin
        rep_len  = LEN_W'(7);
        rep_b[3] = secs[31:24];
        rep_b[4] = secs[23:16];
        rep_b[5] = secs[15:8];
        rep_b[6] = secs[7:0];
      end
      OP_TIME_WR: begin
        rep_len = LEN_W'(3);
        time_ld = (pkt_n >= CNT_W'(6));
      end
      OP_POWER_OFF: begin
        rep_len = LEN_W'(3);
        rep_act = ACT_SHUTDOWN;
      end
      OP_SYS_RESET: begin
        rep_len = LEN_W'(3);
        rep_act = ACT_RESET;
      end
      OP_NOP_SRV, OP_NOP_RATE, OP_NOP_LIST, OP_NOP_PWR: begin
        rep_len = LEN_W'(3);
      end
      OP_WIRE_RW, OP_WIRE_CMB: begin
        if ((op == OP_WIRE_RW) && (pkt_n == CNT_W'(4))) begin
          rep_len = LEN_W'(3);
        end else begin
          rep_len  = LEN_W'(4);
          rep_b[0] = TYPE_ERR;
          rep_b[1] = ERR_CODE;
          rep_b[2] = TYPE_CTRL;
          rep_b[3] = op;
        end
      end
      default: rep_len = '0;
    endcase
  end

  cpr_seconds #(.W(SEC_W)) u_secs (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(accept && time_ld),
    .load_val({pkt_b[2], pkt_b[3], pkt_b[4], pkt_b[5]}), .secs(secs)
  );

  assign cmd_load   = accept && (rep_len != '0);
  assign poll_serve = tx_free && !cmd_load && poll_pend;

  cpr_poll_gen #(.PERIOD(POLL_PERIOD)) u_poll (
    .clk(clk), .rst_n(rst_n), .cfg_we(accept && ap_we), .cfg_en(ap_en),
    .serve(poll_serve), .pend(poll_pend)
  );

  always_comb begin
    if (cmd_load) begin
      ld_b   = rep_b;
      ld_len = rep_len;
      ld_act = rep_act;
    end else begin
      ld_b    = '0;
      ld_b[0] = TYPE_PERIPH;
      ld_b[1] = POLL_TAG;
      ld_len  = LEN_W'(2);
      ld_act  = ACT_NONE;
    end
  end

  cpr_reply_tx #(.MAXB(REPLY_MAX), .LW(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(cmd_load || poll_serve),
    .load_bytes(ld_b), .load_len(ld_len), .load_act(ld_act),
    .free(tx_free), .out_valid(out_valid), .out_first(out_first),
    .out_last(out_last), .out_data(out_data), .out_len(out_len),
    .shut_pulse(shutdown_req), .rst_pulse(reset_req)
  );
endmodule

// File: rtl/cmd_responder_chk.sv
module cmd_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_first,
  input logic       out_last,
  input logic [7:0] out_data,
  input logic [2:0] out_len,
  input logic       shutdown_req,
  input logic       reset_req
);
  p_len_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 3'd2) && (out_len <= 3'd7));

  p_idle_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_len == 3'd0) && !out_first && !out_last);

  p_continue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && !out_first && $stable(out_len)));

  p_ack_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first && (out_len == 3'd3)) |-> (out_data == 8'h01));

  p_shut_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(out_valid && out_last));

  p_reset_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(out_valid && out_last));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req || reset_req) |=> !(shutdown_req || reset_req));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reset_req));
endmodule

bind cmd_responder cmd_responder_chk chk_i (.*);

// File: tb/cmd_responder_tb_top.sv
module cmd_responder_tb_top;
  localparam int PERIOD = 40;
  localparam logic [7:0] ERRC = 8'h05;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       sec_tick = 1'b0;
  logic       out_valid, out_first, out_last, shutdown_req, reset_req;
  logic [7:0] out_data;
  logic [2:0] out_len;

  always #10 clk = ~clk;

  cmd_responder #(.POLL_PERIOD(PERIOD), .ERR_CODE(ERRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .sec_tick(sec_tick),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_data(out_data), .out_len(out_len), .shutdown_req(shutdown_req),
    .reset_req(reset_req)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  string cur_req = "R12";
  bit    done = 1'b0;

  // reference model state
  logic [7:0]  mq[$];
  logic [7:0]  rep[$];
  logic [7:0]  m_pkt[$];
  logic [7:0]  m_cur[$];
  bit          m_open, m_ready, m_first, m_pen, m_pend;
  int          m_len, m_act, m_pcnt;
  logic [31:0] m_secs;
  bit          e_shut, e_rst;
  bit          t_last, t_free, t_loaded, t_wrap, t_pend_pre, t_ovr, t_ld, t_en, t_serve;
  int          t_act, t_np;
  logic [7:0]  t_op;
  logic [31:0] t_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_pkt.delete(); m_cur.delete();
      m_open = 0; m_ready = 0; m_first = 0; m_pen = 0; m_pend = 0;
      m_len = 0; m_act = 0; m_pcnt = 0; m_secs = 0; e_shut = 0; e_rst = 0;
    end else begin
      t_last = (mq.size() == 1);
      t_free = (mq.size() <= 1);
      e_shut = t_last && (m_act == 1);
      e_rst  = t_last && (m_act == 2);
      if (mq.size() > 0) void'(mq.pop_front());
      m_first = 0;
      t_loaded = 0; t_ovr = 0; t_ld = 0; t_val = 0;
      t_pend_pre = m_pend;
      t_wrap = m_pen && (m_pcnt == PERIOD - 1);
      if (m_pen) m_pcnt = t_wrap ? 0 : m_pcnt + 1;
      if (m_ready && m_pkt.size() >= 2 && m_pkt[0] == 8'h01 && t_free) begin
        t_op = m_pkt[1];
        t_np = m_pkt.size() - 2;
        rep.delete();
        t_act = 0;
        case (t_op)
          8'h01: begin
            rep = '{8'h01, 8'h00, t_op};
            t_en = (t_np >= 1) && (m_pkt[2] != 8'h00);
            if (t_en != m_pen) begin m_pen = t_en; m_pcnt = 0; t_ovr = 1; end
          end
          8'h03: rep = '{8'h01, 8'h00, t_op, m_secs[31:24], m_secs[23:16], m_secs[15:8], m_secs[7:0]};
          8'h09: begin
            rep = '{8'h01, 8'h00, t_op};
            if (t_np >= 4) begin t_ld = 1; t_val = {m_pkt[2], m_pkt[3], m_pkt[4], m_pkt[5]}; end
          end
          8'h0A: begin rep = '{8'h01, 8'h00, t_op}; t_act = 1; end
          8'h11: begin rep = '{8'h01, 8'h00, t_op}; t_act = 2; end
          8'h13, 8'h14, 8'h19, 8'h21: rep = '{8'h01, 8'h00, t_op};
          8'h22: if (t_np == 2) rep = '{8'h01, 8'h00, t_op};
                 else rep = '{8'h02, ERRC, 8'h01, t_op};
          8'h25: rep = '{8'h02, ERRC, 8'h01, t_op};
          default: ;
        endcase
        if (rep.size() > 0) begin
          mq = rep; m_len = rep.size(); m_first = 1; m_act = t_act; t_loaded = 1;
        end
      end
      t_serve = t_free && !t_loaded && t_pend_pre;
      if (t_serve) begin
        mq = '{8'h00, 8'h40}; m_len = 2; m_first = 1; m_act = 0;
      end
      m_pend = (t_pend_pre && !t_serve) || t_wrap;
      if (t_ovr) m_pend = 0;
      if (t_ld) m_secs = t_val;
      else if (sec_tick) m_secs = m_secs + 1;
      m_ready = 0;
      if (in_valid) begin
        if (in_first) begin m_cur.delete(); m_cur.push_back(in_data); m_open = 1; end
        else if (m_open) m_cur.push_back(in_data);
        if (in_last && m_open) begin m_pkt = m_cur; m_ready = 1; m_open = 0; end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  logic        x_valid, x_first, x_last;
  logic [7:0]  x_data;
  logic [2:0]  x_len;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      x_valid = (mq.size() > 0);
      x_first = x_valid && m_first;
      x_last  = (mq.size() == 1);
      x_data  = x_valid ? mq[0] : out_data;
      x_len   = x_valid ? 3'(m_len) : 3'd0;
      checks++;
      if (out_valid !== x_valid || out_first !== x_first || out_last !== x_last ||
          out_data !== x_data || out_len !== x_len ||
          shutdown_req !== e_shut || reset_req !== e_rst) begin
        failures++;
        $display("FAIL %s cyc=%0d actual v=%b f=%b l=%b d=%h len=%0d sd=%b rs=%b expected v=%b f=%b l=%b d=%h len=%0d sd=%b rs=%b",
                 cur_req, cyc, out_valid, out_first, out_last, out_data, out_len, shutdown_req, reset_req,
                 x_valid, x_first, x_last, x_data, x_len, e_shut, e_rst);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [7:0] pk[$];

  task automatic send_pkt();
    for (int i = 0; i < pk.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pk[i];
      in_first = (i == 0); in_last = (i == pk.size() - 1);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic one(input int n);
    send_pkt();
    idle(n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: idle outputs after reset
    checks++;
    if (out_valid !== 1'b0 || out_len !== 3'd0 || shutdown_req !== 1'b0 || reset_req !== 1'b0) begin
      failures++;
      $display("FAIL R12 actual v=%b len=%0d sd=%b rs=%b expected 0 0 0 0", out_valid, out_len, shutdown_req, reset_req);
    end
    cur_req = "R12/R3"; pk = '{8'h01, 8'h03}; one(12);

    cur_req = "R5/R3";
    sec_tick = 1'b1; idle(5); sec_tick = 1'b0;
    pk = '{8'h01, 8'h03}; one(12);

    cur_req = "R4";
    pk = '{8'h01, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78}; one(8);
    pk = '{8'h01, 8'h03}; one(12);
    pk = '{8'h01, 8'h09, 8'hAA, 8'hBB}; one(8);
    pk = '{8'h01, 8'h03}; one(12);
    sec_tick = 1'b1;
    pk = '{8'h01, 8'h09, 8'hFF, 8'hFF, 8'hFF, 8'hFE}; one(8);
    sec_tick = 1'b0;
    pk = '{8'h01, 8'h03}; one(12);

    cur_req = "R2/R9";
    pk = '{8'h01, 8'h13}; one(8);
    pk = '{8'h01, 8'h14, 8'h07}; one(8);
    pk = '{8'h01, 8'h19}; one(8);
    pk = '{8'h01, 8'h21, 8'h01}; one(8);
    pk = '{8'h01, 8'h22, 8'h50, 8'h01}; one(8);

    cur_req = "R6";
    pk = '{8'h01, 8'h25, 8'h10, 8'h20}; one(8);
    pk = '{8'h01, 8'h22, 8'h50}; one(8);
    pk = '{8'h01, 8'h22, 8'h50, 8'h01, 8'h02}; one(8);

    cur_req = "R7";
    pk = '{8'h01, 8'h07, 8'h00}; one(8);
    pk = '{8'h01, 8'h0C, 8'h00, 8'h00, 8'h00, 8'h00}; one(8);
    pk = '{8'h01, 8'h03}; one(12);

    cur_req = "R1";
    pk = '{8'h00, 8'h2C}; one(8);
    pk = '{8'h04, 8'h03}; one(8);
    pk = '{8'h01}; one(8);
    @(negedge clk); in_valid = 1'b1; in_first = 1'b0; in_last = 1'b0; in_data = 8'h01;
    @(negedge clk); in_data = 8'h03; in_last = 1'b1;
    idle(8);

    cur_req = "R11";
    pk = '{8'h01, 8'h0A}; one(8);
    pk = '{8'h01, 8'h11}; one(8);
    pk = '{8'h01, 8'h0A}; send_pkt(); pk = '{8'h01, 8'h11}; one(4);
    idle(8);

    cur_req = "R10";
    pk = '{8'h01, 8'h03}; send_pkt();
    pk = '{8'h01, 8'h09, 8'h00, 8'h00, 8'h00, 8'h01}; one(12);
    pk = '{8'h01, 8'h03}; send_pkt();
    pk = '{8'h01, 8'h13}; one(12);
    pk = '{8'h01, 8'h03}; one(12);

    cur_req = "R8";
    pk = '{8'h01, 8'h01, 8'h05}; one(100);
    for (int k = 0; k < 12; k++) begin
      pk = '{8'h01, 8'h03}; one(7 + k % 3);
    end
    pk = '{8'h01, 8'h01, 8'h07}; one(60);
    pk = '{8'h01, 8'h01, 8'h00}; one(60);
    pk = '{8'h01, 8'h01, 8'h09}; one(20);
    pk = '{8'h01, 8'h01}; one(60);
    pk = '{8'h01, 8'h01, 8'h01}; one(45);

    idle(10);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule